// File: doc/BRIEF.md
# Atomic Swap and Fetch-Add Memory Unit

This block owns a small word-wide synchronous RAM and carries out two indivisible read-modify-write operations on it: an exchange, which stores the requester's source value and hands back what the word held before, and a fetch-and-add, which stores the old word plus the source value and also hands back the old word. The returned value is meant to be written back into the requester's source register. A requester can therefore build locks, tickets and counters on top of it.

The target word is found by adding a signed displacement to two base register values. Each base is given as an index plus a value. Index zero names a register that always reads as zero, so one operand shape covers displacement-only, one-register and two-register addressing. Only a register source with a memory destination is a legal operand form. A request with any other form is refused with an error pulse and leaves the RAM alone.

A legal request is taken only while the unit is idle. The unit then steps through read, write and done. While it is busy it ignores new requests, so no other access can come between the read and the write.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The word addressed is (sign-extended displacement + base A term + base B term) taken modulo DEPTH (DEPTH is a power of two; default 256).
- R2: A base whose index is 0 adds zero to the address, whatever value is presented with it.
- R3: Exchange (req_op = 0) stores req_src_val in the addressed word and returns the word's previous contents on result.
- R4: Fetch-and-add (req_op = 1) stores previous contents plus req_src_val (modulo 2^32) and returns the previous contents on result.
- R5: The displacement is a DISP_W-bit two's-complement number, so a negative displacement addresses below the base sum.
- R6: Operand kind encoding is 0 register, 1 immediate, 2 memory, 3 label. A request is legal only with source kind 0 and destination kind 2. An illegal request accepted while idle raises err for exactly one cycle on the cycle after it is sampled, never raises done, leaves ready high and leaves memory unchanged.
- R7: A legal request sampled with ready high drops ready on the next cycle and raises done three cycles after the sampling edge. Requests presented while ready is low are ignored.
- R8: While reset is high and on the cycle after it, ready is 1 and done and err are 0.
- R9: done and err are single-cycle pulses and are never high together. result holds the returned value while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 exchange, 1 fetch-and-add |
| req_src_kind | input | 2 | Source operand kind |
| req_dst_kind | input | 2 | Destination operand kind |
| req_disp | input | DISP_W | Signed displacement |
| req_base_a_idx | input | RIDX_W | Base A register index (0 = zero register) |
| req_base_a_val | input | DATA_W | Base A register value |
| req_base_b_idx | input | RIDX_W | Base B register index (0 = zero register) |
| req_base_b_val | input | DATA_W | Base B register value |
| req_src_val | input | DATA_W | Source register value |
| ready | output | 1 | Unit idle, request will be sampled |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-form pulse |
| result | output | DATA_W | Previous word contents for the source register |

## Verification
On every cycle the assertions check the handshake and timing: quiet outputs around reset, the fixed three-cycle latency from a legal sample to done, ready dropping once a request is taken, the err pulse after an illegal form, and the pulse shape and mutual exclusion of done and err. The data behaviour can only be shown by the bench's scenarios, which read words back through a zero-add fetch. These are the address arithmetic with wrap, the zero register, negative displacement, exchange and fetch-add values including 32-bit overflow, memory left untouched by illegal forms, and requests ignored while the unit is busy.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_IMM = 2'd1,
    KIND_MEM = 2'd2,
    KIND_LBL = 2'd3
  } opnd_kind_e;

  typedef enum logic {
    OP_SWAP = 1'b0,
    OP_FADD = 1'b1
  } rmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } rmw_state_e;

  localparam int NUM_BASE = 2;

endpackage

// File: rtl/rmw_addr_gen.sv
module rmw_addr_gen #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 3,
  parameter int ADDR_W = 8
) (
  input  logic [DISP_W-1:0] disp,
  input  logic [RIDX_W-1:0] idx_a,
  input  logic [DATA_W-1:0] val_a,
  input  logic [RIDX_W-1:0] idx_b,
  input  logic [DATA_W-1:0] val_b,
  output logic [ADDR_W-1:0] addr
);
  import atomic_rmw_pkg::*;

  localparam int EXT_W = DATA_W - DISP_W;

  logic [RIDX_W-1:0] idx  [NUM_BASE];
  logic [DATA_W-1:0] val  [NUM_BASE];
  logic [DATA_W-1:0] term [NUM_BASE];
  logic [DATA_W-1:0] disp_ext;

  assign idx[0] = idx_a;
  assign idx[1] = idx_b;
  assign val[0] = val_a;
  assign val[1] = val_b;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  // register index zero is hardwired to read zero
  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    assign term[g] = (idx[g] == '0) ? '0 : val[g];
  end

  always_comb begin
    addr = ADDR_W'(disp_ext);
    for (int i = 0; i < NUM_BASE; i++) begin
      addr = addr + ADDR_W'(term[i]);
    end
  end

endmodule

// File: rtl/rmw_ram.sv
module rmw_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_legal,
  input  logic              req_op,
  input  logic [DATA_W-1:0] req_src_val,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] result
);
  import atomic_rmw_pkg::*;

  rmw_state_e        state;
  rmw_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= OP_SWAP;
      addr_q <= '0;
      src_q  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_legal) begin
              op_q   <= rmw_op_e'(req_op);
              addr_q <= req_addr;
              src_q  <= req_src_val;
              state  <= ST_READ;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: begin
          result <= ram_rdata;
          done   <= 1'b1;
          state  <= ST_DONE;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (state == ST_IDLE);
  assign ram_addr  = addr_q;
  assign ram_we    = (state == ST_WRITE);
  assign ram_wdata = (op_q == OP_FADD) ? (ram_rdata + src_q) : src_q;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [1:0]        req_src_kind,
  input  logic [1:0]        req_dst_kind,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [RIDX_W-1:0] req_base_a_idx,
  input  logic [DATA_W-1:0] req_base_a_val,
  input  logic [RIDX_W-1:0] req_base_b_idx,
  input  logic [DATA_W-1:0] req_base_b_val,
  input  logic [DATA_W-1:0] req_src_val,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] result
);
  import atomic_rmw_pkg::*;

  localparam int ADDR_W = $clog2(DEPTH);

  logic              legal;
  logic [ADDR_W-1:0] eff_addr;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  assign legal = (req_src_kind == KIND_REG) && (req_dst_kind == KIND_MEM);

  rmw_addr_gen #(
    .DATA_W(DATA_W), .DISP_W(DISP_W), .RIDX_W(RIDX_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .disp (req_disp),
    .idx_a(req_base_a_idx),
    .val_a(req_base_a_val),
    .idx_b(req_base_b_idx),
    .val_b(req_base_b_val),
    .addr (eff_addr)
  );

  rmw_sequencer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_legal  (legal),
    .req_op     (req_op),
    .req_src_val(req_src_val),
    .req_addr   (eff_addr),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata),
    .ready      (ready),
    .done       (done),
    .err        (err),
    .result     (result)
  );

  rmw_ram #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_addr),
    .wdata(ram_wdata),
    .raddr(ram_addr),
    .rdata(ram_rdata)
  );

endmodule

// File: rtl/atomic_rmw_unit_checker.sv
module atomic_rmw_unit_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_src_kind,
  input logic [1:0] req_dst_kind,
  input logic       ready,
  input logic       done,
  input logic       err
);
  import atomic_rmw_pkg::*;

  logic form_ok;
  assign form_ok = (req_src_kind == KIND_REG) && (req_dst_kind == KIND_MEM);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (ready && !done && !err));

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && form_ok) |-> ##3 done);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && form_ok) |=> !ready);

  assert_illegal_err_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && !form_ok) |=> (err && !done && ready));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req_valid && ready && !form_ok));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

endmodule

bind atomic_rmw_unit atomic_rmw_unit_checker u_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_src_kind(req_src_kind),
  .req_dst_kind(req_dst_kind),
  .ready       (ready),
  .done        (done),
  .err         (err)
);

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 256;
  localparam int DISP_W = 16;
  localparam int RIDX_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_op = 1'b0;
  logic [1:0]        req_src_kind = 2'd0;
  logic [1:0]        req_dst_kind = 2'd2;
  logic [DISP_W-1:0] req_disp = '0;
  logic [RIDX_W-1:0] req_base_a_idx = '0;
  logic [DATA_W-1:0] req_base_a_val = '0;
  logic [RIDX_W-1:0] req_base_b_idx = '0;
  logic [DATA_W-1:0] req_base_b_val = '0;
  logic [DATA_W-1:0] req_src_val = '0;
  logic              ready, done, err;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  atomic_rmw_unit #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .DISP_W(DISP_W), .RIDX_W(RIDX_W)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_src_kind(req_src_kind), .req_dst_kind(req_dst_kind),
    .req_disp(req_disp),
    .req_base_a_idx(req_base_a_idx), .req_base_a_val(req_base_a_val),
    .req_base_b_idx(req_base_b_idx), .req_base_b_val(req_base_b_val),
    .req_src_val(req_src_val),
    .ready(ready), .done(done), .err(err), .result(result)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic op, input logic [1:0] sk, input logic [1:0] dk,
                       input logic [15:0] disp, input logic [2:0] ia, input logic [31:0] va,
                       input logic [2:0] ib, input logic [31:0] vb, input logic [31:0] src);
    req_op = op; req_src_kind = sk; req_dst_kind = dk; req_disp = disp;
    req_base_a_idx = ia; req_base_a_val = va;
    req_base_b_idx = ib; req_base_b_val = vb;
    req_src_val = src; req_valid = 1'b1;
  endtask

  // legal request with strict cycle checks; returns the old word
  task automatic run_op(input logic op, input logic [15:0] disp,
                        input logic [2:0] ia, input logic [31:0] va,
                        input logic [2:0] ib, input logic [31:0] vb,
                        input logic [31:0] src, output logic [31:0] old);
    @(negedge clk);
    drive(op, 2'd0, 2'd2, disp, ia, va, ib, vb, src);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 ready low after accept", 32'(ready), 32'd0);
    @(negedge clk);
    check("R7 no early done", 32'(done), 32'd0);
    @(negedge clk);
    check("R7 done at third cycle", 32'(done), 32'd1);
    check("R9 no err with done", 32'(err), 32'd0);
    old = result;
    @(negedge clk);
    check("R9 done single cycle", 32'(done), 32'd0);
    check("R7 ready back", 32'(ready), 32'd1);
  endtask

  task automatic poke(input logic [15:0] a, input logic [31:0] v);
    logic [31:0] dummy;
    run_op(1'b0, a, 3'd0, 32'd0, 3'd0, 32'd0, v, dummy);
  endtask

  task automatic peek(input logic [15:0] a, output logic [31:0] v);
    run_op(1'b1, a, 3'd0, 32'd0, 3'd0, 32'd0, 32'd0, v);
  endtask

  task automatic t_reset_R8;
    check("R8 ready in reset", 32'(ready), 32'd1);
    check("R8 done in reset", 32'(done), 32'd0);
    check("R8 err in reset", 32'(err), 32'd0);
  endtask

  task automatic t_exchange_R3;
    logic [31:0] v;
    poke(16'd5, 32'h0000_A5A5);
    run_op(1'b0, 16'd5, 3'd0, 0, 3'd0, 0, 32'h1234_5678, v);
    check("R3 exchange returns old", v, 32'h0000_A5A5);
    peek(16'd5, v);
    check("R3 exchange stored src", v, 32'h1234_5678);
  endtask

  task automatic t_fetchadd_R4;
    logic [31:0] v;
    poke(16'd10, 32'd100);
    run_op(1'b1, 16'd10, 3'd0, 0, 3'd0, 0, 32'd23, v);
    check("R4 fetch-add returns old", v, 32'd100);
    peek(16'd10, v);
    check("R4 fetch-add sum stored", v, 32'd123);
    poke(16'd11, 32'hFFFF_FFFF);
    run_op(1'b1, 16'd11, 3'd0, 0, 3'd0, 0, 32'd2, v);
    check("R4 overflow returns old", v, 32'hFFFF_FFFF);
    peek(16'd11, v);
    check("R4 overflow wraps", v, 32'd1);
  endtask

  task automatic t_address_R1;
    logic [31:0] v;
    run_op(1'b0, 16'd3, 3'd1, 32'd4, 3'd2, 32'd8, 32'h77, v);
    peek(16'd15, v);
    check("R1 three-term address", v, 32'h77);
    run_op(1'b0, 16'd0, 3'd4, 32'(DEPTH + 20), 3'd0, 0, 32'h2020, v);
    peek(16'd20, v);
    check("R1 address wraps modulo depth", v, 32'h2020);
  endtask

  task automatic t_zero_reg_R2;
    logic [31:0] v;
    poke(16'd57, 32'h5757);
    run_op(1'b0, 16'd7, 3'd0, 32'd50, 3'd0, 32'd9, 32'h99, v);
    peek(16'd7, v);
    check("R2 zero register ignored value", v, 32'h99);
    peek(16'd57, v);
    check("R2 value not added", v, 32'h5757);
  endtask

  task automatic t_negdisp_R5;
    logic [31:0] v;
    run_op(1'b0, 16'hFFFC, 3'd3, 32'd34, 3'd0, 0, 32'h55, v);
    peek(16'd30, v);
    check("R5 negative displacement", v, 32'h55);
  endtask

  task automatic illegal_one(input logic [1:0] sk, input logic [1:0] dk);
    @(negedge clk);
    drive(1'b0, sk, dk, 16'd40, 3'd0, 0, 3'd0, 0, 32'hDEAD);
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 err pulse", 32'(err), 32'd1);
    check("R6 no done", 32'(done), 32'd0);
    check("R6 ready stays", 32'(ready), 32'd1);
    @(negedge clk);
    check("R9 err single cycle", 32'(err), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R6 no late done", 32'(done), 32'd0);
  endtask

  task automatic t_illegal_R6;
    logic [31:0] v;
    poke(16'd40, 32'hCAFE);
    illegal_one(2'd1, 2'd2);
    illegal_one(2'd0, 2'd0);
    illegal_one(2'd2, 2'd2);
    illegal_one(2'd3, 2'd1);
    peek(16'd40, v);
    check("R6 memory untouched", v, 32'hCAFE);
  endtask

  task automatic t_busy_R7;
    logic [31:0] v;
    poke(16'd50, 32'h5050);
    poke(16'd60, 32'h1);
    @(negedge clk);
    drive(1'b0, 2'd0, 2'd2, 16'd60, 3'd0, 0, 3'd0, 0, 32'h6060);
    @(negedge clk);
    req_disp = 16'd50; req_src_val = 32'h0BAD;
    check("R7 busy after accept", 32'(ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R7 done while flooded", 32'(done), 32'd1);
    check("R3 old value under flood", result, 32'h1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R7 only one done", 32'(done), 32'd0);
    peek(16'd50, v);
    check("R7 busy request ignored", v, 32'h5050);
    peek(16'd60, v);
    check("R7 accepted request applied", v, 32'h6060);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_R8();
    rst = 1'b0;
    @(negedge clk);
    check("R8 ready after reset", 32'(ready), 32'd1);
    t_exchange_R3();
    t_fetchadd_R4();
    t_address_R1();
    t_zero_reg_R2();
    t_negdisp_R5();
    t_illegal_R6();
    t_busy_R7();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule